// File: doc/BRIEF.md
# Dirty Page Write Logger

This block keeps a running record of guest pages that have just become dirty. The translation walker sends it an event each time a guest write sets a dirty flag. The event carries the guest-physical address and the value the dirty bit had before the write. For each event that marks a real clean-to-dirty change, the block writes the page-aligned address as one 64-bit entry into a 512-slot buffer. The buffer fills one 4 KB page in memory.

Slots are filled from the top of the page downward. A 16-bit index register names the next free slot and drops by one after each entry. Once the index leaves the range 0..511, the buffer counts as full. From then on, a clean-to-dirty event produces no memory write. It raises an exit request, and that request stays high until software reloads the index. Software normally reloads 511 after it has drained the page.

Top module: `dirty_page_logger`

## Requirements
- R1: After reset the index reads 511, the exit request is low, no memory write is pending and events are accepted.
- R2: An accepted event whose previous dirty bit is 0, with the index in 0..511, issues exactly one memory write. Its address is the base with its low 12 bits treated as zero, plus index × 8. Its data is the event address with bits 11:0 forced to zero. The write is visible on the cycle after acceptance.
- R3: Each logged entry lowers the index by one on the cycle after acceptance. Logging from slot 0 leaves the index at 0xFFFF.
- R4: An accepted event whose previous dirty bit is 1 is ignored. It causes no memory write and changes neither the index nor the exit request.
- R5: When the index is 512 or more (for example 0xFFFF, or a loaded 600), an event whose previous dirty bit is 0 is acknowledged in the same cycle. It issues no write, leaves the index unchanged and sets the exit request on the next cycle. The exit request then stays high until software loads the index.
- R6: A software index write loads the given value and clears the exit request on the next cycle. Events are not accepted during the cycle of the write.
- R7: While a memory write is offered and not taken (valid high, ready low), its address and data stay stable and no new event is accepted.
- R8: Starting from index 511, 512 clean events produce 512 writes to descending slots without an exit request. The 513th event raises the exit request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_valid_i | input | 1 | Dirty-set event present |
| evt_gpa_i | input | 64 | Guest-physical address of the written page |
| evt_prev_dirty_i | input | 1 | Dirty bit value before the write |
| evt_ready_o | output | 1 | Event acknowledged this cycle when valid is high |
| base_i | input | 64 | Buffer page base (bits 11:0 ignored) |
| idx_wr_i | input | 1 | Software write strobe for the index |
| idx_wdata_i | input | 16 | Value loaded into the index |
| idx_o | output | 16 | Current index (next free slot) |
| mem_valid_o | output | 1 | Memory write offered |
| mem_ready_i | input | 1 | Memory accepts the write |
| mem_addr_o | output | 64 | Byte address of the entry |
| mem_data_o | output | 64 | Logged page address |
| exit_req_o | output | 1 | Buffer-full exit request |

## Verification
The bench targets the slot-0 boundary. A design that stopped at 0 instead of wrapping to 0xFFFF would lose the last entry or overwrite slot 0. A design that compared only the low nine bits would treat 0xFFFF or a loaded 600 as a valid slot and write outside the page. Already-dirty events are sent both while the buffer has room and while it is full, to catch a decoder that logs or raises the exit on them. A stalled memory port is held for several cycles, to catch a write whose address moves or an event taken while a write is still pending. A software reload is checked to clear a raised exit request.

// File: rtl/dpl_pkg.sv
package dpl_pkg;
  localparam int unsigned PAGE_SHIFT = 12;
  localparam int unsigned ENTRY_SHIFT = 3;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_SKIP = 2'd1,
    EV_LOG  = 2'd2,
    EV_FULL = 2'd3
  } ev_kind_e;
endpackage

// File: rtl/dpl_index_reg.sv
module dpl_index_reg #(
  parameter int unsigned IDX_W       = 16,
  parameter int unsigned NUM_ENTRIES = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [IDX_W-1:0] load_val_i,
  input  logic             dec_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             full_o
);
  localparam logic [IDX_W-1:0] TOP = IDX_W'(NUM_ENTRIES - 1);
  localparam logic [IDX_W-1:0] LIM = IDX_W'(NUM_ENTRIES);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= TOP;
    else if (load_i)  idx_q <= load_val_i;
    else if (dec_i)   idx_q <= idx_q - IDX_W'(1);
  end

  assign idx_o  = idx_q;
  assign full_o = (idx_q >= LIM);
endmodule

// File: rtl/dpl_event_decode.sv
module dpl_event_decode
  import dpl_pkg::*;
(
  input  logic     valid_i,
  input  logic     ready_i,
  input  logic     prev_dirty_i,
  input  logic     full_i,
  output ev_kind_e kind_o
);
  always_comb begin
    if (!(valid_i && ready_i)) kind_o = EV_NONE;
    else if (prev_dirty_i)     kind_o = EV_SKIP;
    else if (full_i)           kind_o = EV_FULL;
    else                       kind_o = EV_LOG;
  end
endmodule

// File: rtl/dpl_write_port.sv
module dpl_write_port #(
  parameter int unsigned AW = 64,
  parameter int unsigned DW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          launch_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  input  logic          mem_ready_i,
  output logic          mem_valid_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_data_o,
  output logic          can_accept_o
);
  logic          valid_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  assign can_accept_o = !valid_q || mem_ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else if (can_accept_o) begin
      valid_q <= launch_i;
      if (launch_i) begin
        addr_q <= addr_i;
        data_q <= data_i;
      end
    end
  end

  assign mem_valid_o = valid_q;
  assign mem_addr_o  = addr_q;
  assign mem_data_o  = data_q;
endmodule

// File: rtl/dpl_exit_ctrl.sv
module dpl_exit_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic exit_o
);
  logic exit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     exit_q <= 1'b0;
    else if (clr_i)  exit_q <= 1'b0;
    else if (set_i)  exit_q <= 1'b1;
  end

  assign exit_o = exit_q;
endmodule

// File: rtl/dirty_page_logger.sv
module dirty_page_logger
  import dpl_pkg::*;
#(
  parameter int unsigned AW          = 64,
  parameter int unsigned DW          = 64,
  parameter int unsigned IDX_W       = 16,
  parameter int unsigned NUM_ENTRIES = 512
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             evt_valid_i,
  input  logic [DW-1:0]    evt_gpa_i,
  input  logic             evt_prev_dirty_i,
  output logic             evt_ready_o,
  input  logic [AW-1:0]    base_i,
  input  logic             idx_wr_i,
  input  logic [IDX_W-1:0] idx_wdata_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             mem_valid_o,
  input  logic             mem_ready_i,
  output logic [AW-1:0]    mem_addr_o,
  output logic [DW-1:0]    mem_data_o,
  output logic             exit_req_o
);
  localparam int unsigned SLOT_W = $clog2(NUM_ENTRIES);

  ev_kind_e      kind;
  logic          full;
  logic          can_accept;
  logic [AW-1:0] page_base;
  logic [AW-1:0] slot_off;
  logic [AW-1:0] entry_addr;
  logic [DW-1:0] entry_data;

  // software load has priority: no event taken in that cycle
  assign evt_ready_o = can_accept && !idx_wr_i;

  dpl_event_decode u_dec (
    .valid_i      (evt_valid_i),
    .ready_i      (evt_ready_o),
    .prev_dirty_i (evt_prev_dirty_i),
    .full_i       (full),
    .kind_o       (kind)
  );

  dpl_index_reg #(
    .IDX_W       (IDX_W),
    .NUM_ENTRIES (NUM_ENTRIES)
  ) u_idx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (idx_wr_i),
    .load_val_i (idx_wdata_i),
    .dec_i      (kind == EV_LOG),
    .idx_o      (idx_o),
    .full_o     (full)
  );

  assign page_base  = {base_i[AW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};
  assign slot_off   = AW'({idx_o[SLOT_W-1:0], {ENTRY_SHIFT{1'b0}}});
  assign entry_addr = page_base + slot_off;
  assign entry_data = {evt_gpa_i[DW-1:PAGE_SHIFT], {PAGE_SHIFT{1'b0}}};

  dpl_write_port #(
    .AW (AW),
    .DW (DW)
  ) u_wr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .launch_i     (kind == EV_LOG),
    .addr_i       (entry_addr),
    .data_i       (entry_data),
    .mem_ready_i  (mem_ready_i),
    .mem_valid_o  (mem_valid_o),
    .mem_addr_o   (mem_addr_o),
    .mem_data_o   (mem_data_o),
    .can_accept_o (can_accept)
  );

  dpl_exit_ctrl u_exit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (kind == EV_FULL),
    .clr_i  (idx_wr_i),
    .exit_o (exit_req_o)
  );
endmodule

// File: rtl/dpl_checker.sv
module dpl_checker #(
  parameter int unsigned AW          = 64,
  parameter int unsigned DW          = 64,
  parameter int unsigned IDX_W       = 16,
  parameter int unsigned NUM_ENTRIES = 512
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             evt_valid_i,
  input logic             evt_prev_dirty_i,
  input logic             evt_ready_o,
  input logic             idx_wr_i,
  input logic [IDX_W-1:0] idx_wdata_i,
  input logic [IDX_W-1:0] idx_o,
  input logic             mem_valid_o,
  input logic             mem_ready_i,
  input logic [AW-1:0]    mem_addr_o,
  input logic [DW-1:0]    mem_data_o,
  input logic             exit_req_o
);
  logic acc;
  logic room;
  assign acc  = evt_valid_i && evt_ready_o;
  assign room = (idx_o < IDX_W'(NUM_ENTRIES));

  p_log_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !evt_prev_dirty_i && room |=> mem_valid_o && (idx_o == $past(idx_o) - IDX_W'(1)));

  p_aligned_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> (mem_data_o[11:0] == 12'h000) && (mem_addr_o[2:0] == 3'b000));

  p_skip_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && evt_prev_dirty_i |=> !mem_valid_o && $stable(idx_o) && $stable(exit_req_o));

  p_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && !evt_prev_dirty_i && !room |=> exit_req_o && !mem_valid_o && $stable(idx_o));

  p_exit_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_req_o && !idx_wr_i |=> exit_req_o);

  p_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr_i |=> !exit_req_o && (idx_o == $past(idx_wdata_i)));

  p_load_block_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idx_wr_i |-> !evt_ready_o);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o));

  p_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |-> !evt_ready_o);
endmodule

bind dirty_page_logger dpl_checker #(
  .AW (AW), .DW (DW), .IDX_W (IDX_W), .NUM_ENTRIES (NUM_ENTRIES)
) u_chk (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .evt_valid_i      (evt_valid_i),
  .evt_prev_dirty_i (evt_prev_dirty_i),
  .evt_ready_o      (evt_ready_o),
  .idx_wr_i         (idx_wr_i),
  .idx_wdata_i      (idx_wdata_i),
  .idx_o            (idx_o),
  .mem_valid_o      (mem_valid_o),
  .mem_ready_i      (mem_ready_i),
  .mem_addr_o       (mem_addr_o),
  .mem_data_o       (mem_data_o),
  .exit_req_o       (exit_req_o)
);

// File: tb/tb_dirty_page_logger.sv
`timescale 1ns/1ps
module tb_dirty_page_logger;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        evt_valid_i = 1'b0;
  logic [63:0] evt_gpa_i = '0;
  logic        evt_prev_dirty_i = 1'b0;
  logic        evt_ready_o;
  logic [63:0] base_i = 64'h0000_0000_8765_4ABC;
  logic        idx_wr_i = 1'b0;
  logic [15:0] idx_wdata_i = '0;
  logic [15:0] idx_o;
  logic        mem_valid_o;
  logic        mem_ready_i = 1'b1;
  logic [63:0] mem_addr_o;
  logic [63:0] mem_data_o;
  logic        exit_req_o;

  localparam logic [63:0] PAGE = 64'h0000_0000_8765_4000;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  dirty_page_logger dut (.*);

  typedef struct packed {
    logic        load;
    logic [15:0] lval;
    logic        prev;
    logic [63:0] gpa;
    logic        exp_wr;
    logic [15:0] exp_idx;
    logic        exp_exit;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 16'd0,   1'b0, 64'h0000_1234_5678_9ABC, 1'b1, 16'd510,   1'b0},
    '{1'b0, 16'd0,   1'b1, 64'h0000_0000_0000_5000, 1'b0, 16'd510,   1'b0},
    '{1'b0, 16'd0,   1'b0, 64'h0000_0000_0000_0FFF, 1'b1, 16'd509,   1'b0},
    '{1'b1, 16'd1,   1'b0, 64'h0,                   1'b0, 16'd1,     1'b0},
    '{1'b0, 16'd0,   1'b0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 16'd0,     1'b0},
    '{1'b0, 16'd0,   1'b0, 64'h0000_0000_0ABC_D123, 1'b1, 16'hFFFF,  1'b0},
    '{1'b0, 16'd0,   1'b0, 64'h0000_0000_0000_7000, 1'b0, 16'hFFFF,  1'b1},
    '{1'b0, 16'd0,   1'b1, 64'h0000_0000_0000_8000, 1'b0, 16'hFFFF,  1'b1},
    '{1'b1, 16'd600, 1'b0, 64'h0,                   1'b0, 16'd600,   1'b0},
    '{1'b0, 16'd0,   1'b0, 64'h0000_0000_0000_9000, 1'b0, 16'd600,   1'b1},
    '{1'b1, 16'd511, 1'b0, 64'h0,                   1'b0, 16'd511,   1'b0}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_evt(input logic prev, input logic [63:0] gpa);
    @(negedge clk_i);
    evt_valid_i = 1'b1;
    evt_prev_dirty_i = prev;
    evt_gpa_i = gpa;
    @(posedge clk_i);
    @(negedge clk_i);
    evt_valid_i = 1'b0;
    evt_prev_dirty_i = 1'b0;
  endtask

  task automatic load_idx(input logic [15:0] v);
    @(negedge clk_i);
    idx_wr_i = 1'b1;
    idx_wdata_i = v;
    @(posedge clk_i);
    @(negedge clk_i);
    idx_wr_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] m_idx;
    int writes;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 idx", 64'(idx_o), 64'd511);
    chk("R1 exit", 64'(exit_req_o), 64'd0);
    chk("R1 valid", 64'(mem_valid_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready", 64'(evt_ready_o), 64'd1);

    // table walk: R2 R3 R4 R5 R6
    m_idx = 16'd511;
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].load) begin
        load_idx(VEC[i].lval);
        m_idx = VEC[i].lval;
        chk("R6 load idx", 64'(idx_o), 64'(VEC[i].exp_idx));
        chk("R6 exit clr", 64'(exit_req_o), 64'(VEC[i].exp_exit));
      end else begin
        send_evt(VEC[i].prev, VEC[i].gpa);
        chk(VEC[i].prev ? "R4 no write" : "R2/R5 write", 64'(mem_valid_o), 64'(VEC[i].exp_wr));
        if (VEC[i].exp_wr) begin
          chk("R2 addr", mem_addr_o, PAGE + 64'(m_idx) * 64'd8);
          chk("R2 data", mem_data_o, {VEC[i].gpa[63:12], 12'h000});
        end
        chk("R3 idx", 64'(idx_o), 64'(VEC[i].exp_idx));
        chk("R5 exit", 64'(exit_req_o), 64'(VEC[i].exp_exit));
        m_idx = idx_o;
      end
    end

    // R6: no event taken during software write
    @(negedge clk_i);
    idx_wr_i = 1'b1;
    idx_wdata_i = 16'd300;
    evt_valid_i = 1'b1;
    #1 chk("R6 ready low", 64'(evt_ready_o), 64'd0);
    @(posedge clk_i);
    @(negedge clk_i);
    idx_wr_i = 1'b0;
    evt_valid_i = 1'b0;
    chk("R6 no write", 64'(mem_valid_o), 64'd0);
    chk("R6 idx", 64'(idx_o), 64'd300);

    // R7: backpressure
    mem_ready_i = 1'b0;
    send_evt(1'b0, 64'h0000_0000_00CC_C000);
    chk("R7 valid", 64'(mem_valid_o), 64'd1);
    chk("R7 addr", mem_addr_o, PAGE + 64'd300 * 64'd8);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk_i);
      chk("R7 held", 64'(mem_valid_o), 64'd1);
      chk("R7 addr stable", mem_addr_o, PAGE + 64'd300 * 64'd8);
      chk("R7 ready low", 64'(evt_ready_o), 64'd0);
    end
    mem_ready_i = 1'b1;
    @(negedge clk_i);
    chk("R7 drained", 64'(mem_valid_o), 64'd0);
    chk("R7 idx", 64'(idx_o), 64'd299);

    // R8: full page run
    load_idx(16'd511);
    writes = 0;
    for (int k = 0; k < 512; k++) begin
      send_evt(1'b0, 64'(k) << 12);
      if (mem_valid_o && mem_addr_o == PAGE + 64'(511 - k) * 64'd8) writes++;
    end
    chk("R8 writes", 64'(writes), 64'd512);
    chk("R8 idx", 64'(idx_o), 64'hFFFF);
    chk("R8 no exit yet", 64'(exit_req_o), 64'd0);
    send_evt(1'b0, 64'h0000_0000_0123_4000);
    chk("R8 exit", 64'(exit_req_o), 64'd1);
    chk("R8 no write", 64'(mem_valid_o), 64'd0);
    load_idx(16'd511);
    chk("R8 exit cleared", 64'(exit_req_o), 64'd0);

    finish_run();
  end
endmodule